// File: doc/BRIEF.md
# Self-Test Sequencer with Signature Verdict

This block runs a complete logic self-test from one start pulse. It holds its own pattern source, a small combinational test circuit, and a response compactor. On start it loads both shift registers with known values. It then applies a fixed number of pseudo-random patterns, one per clock, to the test circuit. Each circuit output word is folded into a running signature, so no response is ever stored.

After the last pattern the signature is compared with a good-machine value fixed at build time, and a single pass bit is produced. A build parameter can force one output bit of the test circuit to a constant, which models a stuck-at fault.

The verdict only checks whether two signatures are equal. A faulty circuit that happens to produce the good signature therefore reports pass. This is a known limit of signature compaction, not a defect of the block.

Top module: `selftest_engine`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted and right after it is released, busy, done and pass are all low.
- R2: A start seen high at a clock edge while the block is idle or finished makes busy high from the next cycle. In that first busy cycle both shift registers are loaded: the generator with SEED and the compactor with zero.
- R3: Exactly NPAT patterns are applied, one per clock. Busy stays high for NPAT+2 cycles (one load cycle, NPAT apply cycles, one compare cycle). Done rises NPAT+2 edges after the edge that sampled start.
- R4: Busy and done are never high in the same cycle.
- R5: A start raised while busy is high is ignored. The run ends in the same cycle and gives the same verdict as an undisturbed run.
- R6: Pass can be high only while done is high. Done and pass hold their values until the next accepted start, which clears both.
- R7: The pattern generator is a Fibonacci LFSR with taps given by the TAPS mask (default 8'hB8, so the next state is {s[6:0], s[7]^s[5]^s[4]^s[3]}). It is seeded with SEED (default 8'hA5), so repeated runs give the same verdict.
- R8: The test circuit splits a pattern p into a = p[3:0] and b = p[7:4]. Its output is y[4:0] = a + b and y[7:5] = a[2:0] ^ b[3:1]. When FAULT_EN is set, output bit FAULT_BIT is forced to FAULT_VAL.
- R9: The compactor is a multiple-input shift register with the same taps. Its next state is {m[6:0], feedback} XOR y, where feedback is the XOR of the tapped bits.
- R10: Pass is high in done exactly when the final signature equals GOLDEN. A stuck-at fault that changes the signature, or a wrong GOLDEN value, gives pass low.
- R11: A faulty circuit whose signature equals GOLDEN reports pass (aliasing).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Launches a self-test run when the block is not busy |
| busy | output | 1 | High from the load cycle through the compare cycle |
| done | output | 1 | High once the verdict is available |
| pass | output | 1 | Verdict: high when the signature matched, valid while done is high |

## Verification
Five copies of the block are built, each with a different fault setting and reference signature, and all are run from the same start pulse:
- A fault-free circuit with the correct reference separates a working generator, circuit and compactor from any error in their arithmetic.
- A stuck-at-0 on the low sum bit and a stuck-at-1 on the top XOR bit show that faults in different parts of the circuit change the signature.
- A fault-free circuit given a deliberately wrong reference shows that the verdict depends on the comparison itself.
- A faulty circuit whose reference equals its own faulty signature reproduces aliasing.

A second run started from the finished state, with a start pulse injected partway through it, separates correct restart and repeatability from wrong handling of start while busy.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SEED = 3'd1,
    ST_RUN  = 3'd2,
    ST_CMP  = 3'd3,
    ST_DONE = 3'd4
  } seq_state_e;
endpackage

// File: rtl/pat_lfsr.sv
module pat_lfsr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  output logic [W-1:0] pat
);
  function automatic logic [W-1:0] lfsr_adv(input logic [W-1:0] s);
    return {s[W-2:0], ^(s & TAPS)};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pat <= SEED;
    else if (load) pat <= SEED;
    else if (step) pat <= lfsr_adv(pat);
  end
endmodule

// File: rtl/cut_net.sv
module cut_net #(
  parameter int W         = 8,
  parameter bit FAULT_EN  = 1'b0,
  parameter int FAULT_BIT = 0,
  parameter bit FAULT_VAL = 1'b0
) (
  input  logic [W-1:0] pat,
  output logic [W-1:0] resp
);
  localparam int H = W / 2;

  function automatic logic [W-1:0] cut_eval(input logic [W-1:0] p);
    logic [H-1:0] a;
    logic [H-1:0] b;
    logic [W-1:0] y;
    a = p[H-1:0];
    b = p[W-1:H];
    y[H:0]     = {1'b0, a} + {1'b0, b};
    y[W-1:H+1] = a[H-2:0] ^ b[H-1:1];
    return y;
  endfunction

  logic [W-1:0] clean;
  assign clean = cut_eval(pat);

  generate
    if (FAULT_EN) begin : g_fault
      always_comb begin
        resp            = clean;
        resp[FAULT_BIT] = FAULT_VAL;
      end
    end else begin : g_clean
      assign resp = clean;
    end
  endgenerate
endmodule

// File: rtl/sig_misr.sv
module sig_misr #(
  parameter int           W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic         shift,
  input  logic [W-1:0] resp,
  output logic [W-1:0] sig
);
  function automatic logic [W-1:0] misr_adv(input logic [W-1:0] m, input logic [W-1:0] y);
    return {m[W-2:0], ^(m & TAPS)} ^ y;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sig <= '0;
    else if (clear) sig <= '0;
    else if (shift) sig <= misr_adv(sig, resp);
  end
endmodule

// File: rtl/selftest_engine.sv
module selftest_engine #(
  parameter int           W         = 8,
  parameter logic [W-1:0] TAPS      = 8'hB8,
  parameter logic [W-1:0] SEED      = 8'hA5,
  parameter int           NPAT      = 64,
  parameter logic [W-1:0] GOLDEN    = '0,
  parameter bit           FAULT_EN  = 1'b0,
  parameter int           FAULT_BIT = 0,
  parameter bit           FAULT_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done,
  output logic pass
);
  import selftest_pkg::*;

  localparam int CW = $clog2(NPAT + 1);
  localparam logic [CW-1:0] LAST = CW'(NPAT - 1);

  seq_state_e    state;
  logic [CW-1:0] cnt;
  logic          pass_q;
  logic [W-1:0]  pat;
  logic [W-1:0]  resp;
  logic [W-1:0]  sig;

  // Named internal events used by the checker
  logic seed_evt, run_evt, cmp_evt, last_evt;
  assign seed_evt = (state == ST_SEED);
  assign run_evt  = (state == ST_RUN);
  assign cmp_evt  = (state == ST_CMP);
  assign last_evt = run_evt && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      pass_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) state <= ST_SEED;
        ST_SEED: begin
          cnt   <= '0;
          state <= ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (last_evt) state <= ST_CMP;
        end
        ST_CMP: begin
          pass_q <= (sig == GOLDEN);
          state  <= ST_DONE;
        end
        ST_DONE: if (start) begin
          pass_q <= 1'b0;
          state  <= ST_SEED;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = seed_evt || run_evt || cmp_evt;
  assign done = (state == ST_DONE);
  assign pass = pass_q;

  pat_lfsr #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(seed_evt), .step(run_evt), .pat(pat)
  );

  cut_net #(.W(W), .FAULT_EN(FAULT_EN), .FAULT_BIT(FAULT_BIT), .FAULT_VAL(FAULT_VAL)) u_cut (
    .pat(pat), .resp(resp)
  );

  sig_misr #(.W(W), .TAPS(TAPS)) u_cmp (
    .clk(clk), .rst_n(rst_n), .clear(seed_evt), .shift(run_evt), .resp(resp), .sig(sig)
  );
endmodule

// File: rtl/selftest_chk.sv
module selftest_chk #(
  parameter int NPAT = 64,
  parameter int CW   = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          seed_evt,
  input logic          run_evt,
  input logic          cmp_evt,
  input logic [CW-1:0] cnt
);
  // R2: accepted start leads to a load cycle
  p_start_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> seed_evt);

  // R3: load cycle is followed by the first apply cycle with a zeroed count
  p_seed_then_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seed_evt |=> (run_evt && cnt == '0));

  // R3: the count never reaches NPAT while patterns are applied
  p_run_bounded_r3: assert property (@(posedge clk) disable iff (!rst_n)
    run_evt |-> (int'(cnt) < NPAT));

  // R3: compare is followed by done
  p_cmp_then_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> (done && !busy));

  // R4: busy and done exclusive
  p_busy_done_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R5: start while busy never causes a reload mid-run
  p_start_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (start && run_evt) |=> !seed_evt);

  // R6: pass only with done
  p_pass_in_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);

  // R6: verdict held while no start
  p_verdict_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(pass)));
endmodule

bind selftest_engine selftest_chk #(.NPAT(NPAT), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
  .seed_evt(seed_evt), .run_evt(run_evt), .cmp_evt(cmp_evt), .cnt(cnt)
);

// File: tb/sim_selftest_engine.sv
`timescale 1ns/1ps
module sim_selftest_engine;
  localparam int NP = 64;
  localparam int NI = 5;

  // Independent reference of generator, circuit and compactor
  function automatic logic [7:0] ref_sig(input bit fen, input int fbit, input bit fval);
    logic [7:0] s;
    logic [7:0] m;
    logic [7:0] y;
    int a;
    int b;
    s = 8'hA5;
    m = 8'h00;
    for (int i = 0; i < NP; i++) begin
      a = int'(s[3:0]);
      b = int'(s[7:4]);
      y = 8'((a + b) % 32) | 8'((((a % 8) ^ (b / 2)) % 8) * 32);
      if (fen) y[fbit] = fval;
      m = {m[6], m[5], m[4], m[3], m[2], m[1], m[0], m[7] ^ m[5] ^ m[4] ^ m[3]} ^ y;
      s = {s[6], s[5], s[4], s[3], s[2], s[1], s[0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    end
    return m;
  endfunction

  // Stimulus / expectation table: one entry per instance
  localparam bit         FEN  [NI] = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam int         FBIT [NI] = '{0, 0, 7, 3, 0};
  localparam bit         FVAL [NI] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [7:0] SGOOD = ref_sig(1'b0, 0, 1'b0);
  localparam logic [7:0] SALIAS = ref_sig(1'b1, 3, 1'b1);
  localparam logic [7:0] GOLD [NI] = '{SGOOD, SGOOD, SGOOD, SALIAS, SGOOD ^ 8'h01};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [NI-1:0] busy_v, done_v, pass_v;
  int total = 0;
  int bad = 0;
  bit exp_pass [NI];
  logic [NI-1:0] first_pass;

  always #4 clk = ~clk;

  selftest_engine #(.NPAT(NP), .GOLDEN(GOLD[0]), .FAULT_EN(FEN[0]), .FAULT_BIT(FBIT[0]), .FAULT_VAL(FVAL[0]))
    u0 (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy_v[0]), .done(done_v[0]), .pass(pass_v[0]));
  selftest_engine #(.NPAT(NP), .GOLDEN(GOLD[1]), .FAULT_EN(FEN[1]), .FAULT_BIT(FBIT[1]), .FAULT_VAL(FVAL[1]))
    u1 (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy_v[1]), .done(done_v[1]), .pass(pass_v[1]));
  selftest_engine #(.NPAT(NP), .GOLDEN(GOLD[2]), .FAULT_EN(FEN[2]), .FAULT_BIT(FBIT[2]), .FAULT_VAL(FVAL[2]))
    u2 (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy_v[2]), .done(done_v[2]), .pass(pass_v[2]));
  selftest_engine #(.NPAT(NP), .GOLDEN(GOLD[3]), .FAULT_EN(FEN[3]), .FAULT_BIT(FBIT[3]), .FAULT_VAL(FVAL[3]))
    u3 (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy_v[3]), .done(done_v[3]), .pass(pass_v[3]));
  selftest_engine #(.NPAT(NP), .GOLDEN(GOLD[4]), .FAULT_EN(FEN[4]), .FAULT_BIT(FBIT[4]), .FAULT_VAL(FVAL[4]))
    u4 (.clk(clk), .rst_n(rst_n), .start(start), .busy(busy_v[4]), .done(done_v[4]), .pass(pass_v[4]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Launch a run, count busy cycles; optionally raise start again at busy count 'poke'
  task automatic launch(input int poke, output int nb, output int clash, output int passhi,
                        output bit first_busy);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    nb = 0; clash = 0; passhi = 0;
    first_busy = busy_v[0];
    for (int k = 0; k < 5000; k++) begin
      if (done_v[0]) break;
      if (busy_v[0]) nb++;
      if (busy_v[0] && done_v[0]) clash++;
      if (pass_v[0] && !done_v[0]) passhi++;
      start = (poke > 0 && nb == poke);
      @(negedge clk);
    end
    start = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int nb, clash, passhi;
    bit fb;
    for (int i = 0; i < NI; i++) exp_pass[i] = (ref_sig(FEN[i], FBIT[i], FVAL[i]) == GOLD[i]);

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(busy_v == '0 && done_v == '0 && pass_v == '0, "R1 in reset", int'(busy_v | done_v | pass_v), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_v == '0 && done_v == '0 && pass_v == '0, "R1 after reset", int'(busy_v | done_v | pass_v), 0);

    // First run from idle
    launch(0, nb, clash, passhi, fb);
    chk(fb == 1'b1, "R2 busy after start", int'(fb), 1);
    chk(nb == NP + 2, "R3 busy length", nb, NP + 2);
    chk(clash == 0, "R4 busy/done overlap", clash, 0);
    chk(passhi == 0, "R6 pass outside done", passhi, 0);
    chk(done_v == '1, "R3 all done", int'(done_v), 31);

    // Table walk: verdict per instance
    for (int i = 0; i < NI; i++) begin
      if (i == 3)      chk(pass_v[i] == exp_pass[i], "R11 aliasing fault passes", int'(pass_v[i]), int'(exp_pass[i]));
      else if (i == 0) chk(pass_v[i] == exp_pass[i], "R7/R8/R9 good machine", int'(pass_v[i]), int'(exp_pass[i]));
      else             chk(pass_v[i] == exp_pass[i], "R10 verdict", int'(pass_v[i]), int'(exp_pass[i]));
    end
    chk(exp_pass[0] && exp_pass[3] && !exp_pass[4], "R10 table sanity", int'(exp_pass[4]), 0);
    first_pass = pass_v;

    // R6: hold verdict while idle in done
    repeat (10) @(negedge clk);
    chk(done_v == '1 && pass_v == first_pass, "R6 verdict held", int'(pass_v), int'(first_pass));

    // Second run from done with a start during the run
    launch(20, nb, clash, passhi, fb);
    chk(fb == 1'b1 && done_v[0] == 1'b1, "R6 restart from done", int'(fb), 1);
    chk(nb == NP + 2, "R5 start while busy ignored", nb, NP + 2);
    chk(clash == 0, "R4 overlap run 2", clash, 0);
    chk(pass_v == first_pass, "R7 repeatable verdicts", int'(pass_v), int'(first_pass));

    // Reset during a run clears everything
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat (10) @(negedge clk);
    chk(busy_v == '1, "R2 busy mid run", int'(busy_v), 31);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy_v == '0 && done_v == '0 && pass_v == '0, "R1 reset mid run", int'(busy_v | done_v | pass_v), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(busy_v == '0 && done_v == '0, "R1 idle after reset", int'(busy_v | done_v), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule